// File: doc/BRIEF.md
# Static memory timing converter

This block turns a set of nanosecond timing figures for an external static memory into the clock-cycle counts that a memory controller programs. It is given the master clock frequency in hertz and fourteen times. For the read path and the write path there is a chip-select setup, pulse and recovery time, and a strobe setup, pulse and recovery time. Each path also has a minimum total cycle time. The block returns eight setup and pulse counts and one total cycle count per path.

Every time is rounded up to whole cycles. The conversion uses a 16.16 fixed-point cycles-per-nanosecond factor derived from the clock frequency. After conversion the read and write totals are lengthened when needed, so that every strobe fits its setup, its pulse and its recovery inside the cycle. A one-cycle start pulse captures all inputs. One shared multiply-shift unit then converts the fourteen times one per clock. A one-cycle done pulse marks the moment the new counts appear on the outputs.

Top module: `mem_timing_calc`

## Requirements
- R1: The scale factor is `((clk_hz_i / 10000) << 16) / 100000` in integer arithmetic. A clock below 10 kHz gives a factor of zero, so every nonzero time converts to 0 cycles.
- R2: A nonzero time t converts to `(t * scale + 65535) >> 16` cycles, so any fractional cycle rounds up. At 100 MHz, 10 ns gives 1 cycle and 11 ns gives 2 cycles.
- R3: A time input equal to zero yields 0 cycles for that field, whatever the clock.
- R4: A recovery input equal to zero counts as exactly 1 cycle of recovery. With all times zero, both cycle outputs are 1.
- R5: Setup and pulse outputs saturate at 2^CNT_W-1 (63 by default). The cycle outputs saturate at 2^CYC_W-1 (511 by default). Saturation is applied after the cycle extension, which is computed on unsaturated counts.
- R6: The read cycle output equals the largest of three values: the converted read total, the chip-select read setup+pulse+recovery, and the read-strobe setup+pulse+recovery.
- R7: The write cycle output is formed the same way from the write total, the chip-select write terms and the write-strobe terms.
- R8: A start pulse accepted while idle captures every input. Inputs that change afterwards do not affect that result. done_o rises on the 15th rising edge after the edge that sampled start_i.
- R9: done_o is high for exactly one cycle. All outputs change only on the edge that raises done_o and hold their values between results. Reset clears all outputs to 0.
- R10: A start pulse that arrives while a conversion is in progress is ignored. The running conversion completes with its own captured inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Capture inputs and begin conversion |
| clk_hz_i | input | IN_W | Master clock frequency in Hz |
| cs_rd_setup_ns_i | input | IN_W | Chip-select read setup, ns |
| rd_setup_ns_i | input | IN_W | Read strobe setup, ns |
| cs_wr_setup_ns_i | input | IN_W | Chip-select write setup, ns |
| wr_setup_ns_i | input | IN_W | Write strobe setup, ns |
| cs_rd_pulse_ns_i | input | IN_W | Chip-select read pulse, ns |
| rd_pulse_ns_i | input | IN_W | Read strobe pulse, ns |
| cs_wr_pulse_ns_i | input | IN_W | Chip-select write pulse, ns |
| wr_pulse_ns_i | input | IN_W | Write strobe pulse, ns |
| rd_total_ns_i | input | IN_W | Minimum read cycle, ns |
| wr_total_ns_i | input | IN_W | Minimum write cycle, ns |
| cs_rd_rec_ns_i | input | IN_W | Chip-select read recovery, ns |
| rd_rec_ns_i | input | IN_W | Read strobe recovery, ns |
| cs_wr_rec_ns_i | input | IN_W | Chip-select write recovery, ns |
| wr_rec_ns_i | input | IN_W | Write strobe recovery, ns |
| done_o | output | 1 | One-cycle result-valid pulse |
| cs_rd_setup_o | output | CNT_W | Chip-select read setup, cycles |
| rd_setup_o | output | CNT_W | Read strobe setup, cycles |
| cs_wr_setup_o | output | CNT_W | Chip-select write setup, cycles |
| wr_setup_o | output | CNT_W | Write strobe setup, cycles |
| cs_rd_pulse_o | output | CNT_W | Chip-select read pulse, cycles |
| rd_pulse_o | output | CNT_W | Read strobe pulse, cycles |
| cs_wr_pulse_o | output | CNT_W | Chip-select write pulse, cycles |
| wr_pulse_o | output | CNT_W | Write strobe pulse, cycles |
| rd_cycle_o | output | CYC_W | Extended read cycle, cycles |
| wr_cycle_o | output | CYC_W | Extended write cycle, cycles |

## Verification
Two conditions are hard to reach from the ports. The first is a cycle output that comes from a stretched sum rather than from the given total. The second is a sum that overflows the cycle field while each of its terms still fits below saturation. The bench reaches both by sweeping seven clock frequencies, from below 10 kHz up to the full 32-bit range, against parameter patterns. These patterns scale the times by powers of two and zero some fields in a rotating pattern. Zero recoveries, large recoveries and saturated sums therefore all occur across the runs. A directed run also pulses start and changes every input in the middle of a conversion. It then confirms that the first captured set alone shapes the result.

// File: rtl/mtc_pkg.sv
package mtc_pkg;
  localparam int NPAR = 14;
  // conversion order; indices 0..7 map one-to-one onto strobe outputs
  localparam int P_CSRS = 0;
  localparam int P_RS   = 1;
  localparam int P_CSWS = 2;
  localparam int P_WS   = 3;
  localparam int P_CSRP = 4;
  localparam int P_RP   = 5;
  localparam int P_CSWP = 6;
  localparam int P_WP   = 7;
  localparam int P_RT   = 8;
  localparam int P_WT   = 9;
  localparam int P_CSRR = 10;
  localparam int P_RR   = 11;
  localparam int P_CSWR = 12;
  localparam int P_WR   = 13;
  localparam int NSTROBE = 8;

  typedef enum logic [1:0] {ST_IDLE, ST_CONV, ST_FIN} st_e;
endpackage

// File: rtl/mtc_scale.sv
module mtc_scale #(
  parameter int IN_W = 32
) (
  input  logic [IN_W-1:0] hz_i,
  output logic [IN_W-1:0] scale_o
);
  logic [63:0] hz_ext, per_10k, scaled, quot;
  always_comb begin
    hz_ext  = {{(64-IN_W){1'b0}}, hz_i};
    per_10k = hz_ext / 64'd10000;
    scaled  = per_10k << 16;
    quot    = scaled / 64'd100000;
    scale_o = quot[IN_W-1:0];  // always fits: quot < hz
  end
endmodule

// File: rtl/mtc_conv.sv
module mtc_conv #(
  parameter int IN_W  = 32,
  parameter int RES_W = 2*IN_W - 15
) (
  input  logic [IN_W-1:0]  ns_i,
  input  logic [IN_W-1:0]  scale_i,
  input  logic             is_rec_i,
  output logic [RES_W-1:0] cyc_o
);
  localparam int PW = 2*IN_W + 1;
  logic [PW-1:0] prod;
  always_comb begin
    prod = {{(IN_W+1){1'b0}}, ns_i} * {{(IN_W+1){1'b0}}, scale_i}
           + PW'(65535);
    if (ns_i == '0) cyc_o = is_rec_i ? RES_W'(1) : '0;
    else            cyc_o = prod[PW-1:16];
  end
endmodule

// File: rtl/mtc_sat.sv
module mtc_sat #(
  parameter int IN_W  = 36,
  parameter int OUT_W = 8
) (
  input  logic [IN_W-1:0]  val_i,
  output logic [OUT_W-1:0] val_o
);
  localparam logic [IN_W-1:0] LIMIT = IN_W'((64'd1 << OUT_W) - 64'd1);
  always_comb val_o = (val_i > LIMIT) ? '1 : val_i[OUT_W-1:0];
endmodule

// File: rtl/mem_timing_calc.sv
module mem_timing_calc
  import mtc_pkg::*;
#(
  parameter int IN_W  = 32,
  parameter int CNT_W = 6,
  parameter int CYC_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [IN_W-1:0]  clk_hz_i,
  input  logic [IN_W-1:0]  cs_rd_setup_ns_i,
  input  logic [IN_W-1:0]  rd_setup_ns_i,
  input  logic [IN_W-1:0]  cs_wr_setup_ns_i,
  input  logic [IN_W-1:0]  wr_setup_ns_i,
  input  logic [IN_W-1:0]  cs_rd_pulse_ns_i,
  input  logic [IN_W-1:0]  rd_pulse_ns_i,
  input  logic [IN_W-1:0]  cs_wr_pulse_ns_i,
  input  logic [IN_W-1:0]  wr_pulse_ns_i,
  input  logic [IN_W-1:0]  rd_total_ns_i,
  input  logic [IN_W-1:0]  wr_total_ns_i,
  input  logic [IN_W-1:0]  cs_rd_rec_ns_i,
  input  logic [IN_W-1:0]  rd_rec_ns_i,
  input  logic [IN_W-1:0]  cs_wr_rec_ns_i,
  input  logic [IN_W-1:0]  wr_rec_ns_i,
  output logic             done_o,
  output logic [CNT_W-1:0] cs_rd_setup_o,
  output logic [CNT_W-1:0] rd_setup_o,
  output logic [CNT_W-1:0] cs_wr_setup_o,
  output logic [CNT_W-1:0] wr_setup_o,
  output logic [CNT_W-1:0] cs_rd_pulse_o,
  output logic [CNT_W-1:0] rd_pulse_o,
  output logic [CNT_W-1:0] cs_wr_pulse_o,
  output logic [CNT_W-1:0] wr_pulse_o,
  output logic [CYC_W-1:0] rd_cycle_o,
  output logic [CYC_W-1:0] wr_cycle_o
);
  localparam int RES_W = 2*IN_W - 15;
  localparam int SUM_W = RES_W + 2;
  localparam int IDX_W = $clog2(NPAR);

  st_e              st_q;
  logic [IDX_W-1:0] idx_q;
  logic             done_q;
  logic [IN_W-1:0]  scale_q;
  logic [IN_W-1:0]  par_q [NPAR];
  logic [IN_W-1:0]  par_d [NPAR];
  logic [RES_W-1:0] cyc_q [NPAR];
  logic [CNT_W-1:0] cnt_q [NSTROBE];
  logic [CNT_W-1:0] cnt_w [NSTROBE];
  logic [CYC_W-1:0] rd_cyc_q, wr_cyc_q, rd_cyc_w, wr_cyc_w;

  logic [IN_W-1:0]  scale_w;
  logic [IN_W-1:0]  cur_ns;
  logic             cur_rec;
  logic [RES_W-1:0] conv_w;
  logic [SUM_W-1:0] rd_cs_sum, rd_st_sum, wr_cs_sum, wr_st_sum;
  logic [SUM_W-1:0] rd_need, wr_need;

  always_comb begin
    par_d[P_CSRS] = cs_rd_setup_ns_i;
    par_d[P_RS]   = rd_setup_ns_i;
    par_d[P_CSWS] = cs_wr_setup_ns_i;
    par_d[P_WS]   = wr_setup_ns_i;
    par_d[P_CSRP] = cs_rd_pulse_ns_i;
    par_d[P_RP]   = rd_pulse_ns_i;
    par_d[P_CSWP] = cs_wr_pulse_ns_i;
    par_d[P_WP]   = wr_pulse_ns_i;
    par_d[P_RT]   = rd_total_ns_i;
    par_d[P_WT]   = wr_total_ns_i;
    par_d[P_CSRR] = cs_rd_rec_ns_i;
    par_d[P_RR]   = rd_rec_ns_i;
    par_d[P_CSWR] = cs_wr_rec_ns_i;
    par_d[P_WR]   = wr_rec_ns_i;
  end

  mtc_scale #(.IN_W(IN_W)) u_scale (.hz_i(clk_hz_i), .scale_o(scale_w));

  // shared converter operand select
  always_comb begin
    cur_ns = '0;
    for (int i = 0; i < NPAR; i++)
      if (idx_q == IDX_W'(i)) cur_ns = par_q[i];
    cur_rec = (idx_q >= IDX_W'(P_CSRR));
  end

  mtc_conv #(.IN_W(IN_W), .RES_W(RES_W)) u_conv (
    .ns_i(cur_ns), .scale_i(scale_q), .is_rec_i(cur_rec), .cyc_o(conv_w)
  );

  function automatic logic [SUM_W-1:0] add3(input logic [RES_W-1:0] a,
                                            input logic [RES_W-1:0] b,
                                            input logic [RES_W-1:0] c);
    return SUM_W'(a) + SUM_W'(b) + SUM_W'(c);
  endfunction

  function automatic logic [SUM_W-1:0] max3(input logic [SUM_W-1:0] a,
                                            input logic [SUM_W-1:0] b,
                                            input logic [SUM_W-1:0] c);
    logic [SUM_W-1:0] m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  always_comb begin
    rd_cs_sum = add3(cyc_q[P_CSRS], cyc_q[P_CSRP], cyc_q[P_CSRR]);
    rd_st_sum = add3(cyc_q[P_RS],   cyc_q[P_RP],   cyc_q[P_RR]);
    wr_cs_sum = add3(cyc_q[P_CSWS], cyc_q[P_CSWP], cyc_q[P_CSWR]);
    wr_st_sum = add3(cyc_q[P_WS],   cyc_q[P_WP],   cyc_q[P_WR]);
    rd_need   = max3(SUM_W'(cyc_q[P_RT]), rd_cs_sum, rd_st_sum);
    wr_need   = max3(SUM_W'(cyc_q[P_WT]), wr_cs_sum, wr_st_sum);
  end

  for (genvar g = 0; g < NSTROBE; g++) begin : g_strobe_sat
    mtc_sat #(.IN_W(RES_W), .OUT_W(CNT_W)) u_sat (
      .val_i(cyc_q[g]), .val_o(cnt_w[g])
    );
  end

  mtc_sat #(.IN_W(SUM_W), .OUT_W(CYC_W)) u_rd_sat (.val_i(rd_need), .val_o(rd_cyc_w));
  mtc_sat #(.IN_W(SUM_W), .OUT_W(CYC_W)) u_wr_sat (.val_i(wr_need), .val_o(wr_cyc_w));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      idx_q    <= '0;
      done_q   <= 1'b0;
      scale_q  <= '0;
      rd_cyc_q <= '0;
      wr_cyc_q <= '0;
      for (int i = 0; i < NPAR; i++) begin
        par_q[i] <= '0;
        cyc_q[i] <= '0;
      end
      for (int i = 0; i < NSTROBE; i++) cnt_q[i] <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          for (int i = 0; i < NPAR; i++) par_q[i] <= par_d[i];
          scale_q <= scale_w;
          idx_q   <= '0;
          st_q    <= ST_CONV;
        end
        ST_CONV: begin
          for (int i = 0; i < NPAR; i++)
            if (idx_q == IDX_W'(i)) cyc_q[i] <= conv_w;
          if (idx_q == IDX_W'(NPAR-1)) st_q <= ST_FIN;
          else idx_q <= idx_q + 1'b1;
        end
        ST_FIN: begin
          for (int i = 0; i < NSTROBE; i++) cnt_q[i] <= cnt_w[i];
          rd_cyc_q <= rd_cyc_w;
          wr_cyc_q <= wr_cyc_w;
          done_q   <= 1'b1;
          st_q     <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign done_o        = done_q;
  assign cs_rd_setup_o = cnt_q[P_CSRS];
  assign rd_setup_o    = cnt_q[P_RS];
  assign cs_wr_setup_o = cnt_q[P_CSWS];
  assign wr_setup_o    = cnt_q[P_WS];
  assign cs_rd_pulse_o = cnt_q[P_CSRP];
  assign rd_pulse_o    = cnt_q[P_RP];
  assign cs_wr_pulse_o = cnt_q[P_CSWP];
  assign wr_pulse_o    = cnt_q[P_WP];
  assign rd_cycle_o    = rd_cyc_q;
  assign wr_cycle_o    = wr_cyc_q;
endmodule

// File: rtl/mtc_checker.sv
module mtc_checker
  import mtc_pkg::*;
#(
  parameter int IN_W  = 32,
  parameter int CNT_W = 6,
  parameter int CYC_W = 9
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input st_e              st_i,
  input logic [IN_W-1:0]  scale_i,
  input logic             done_o,
  input logic [CNT_W-1:0] cs_rd_setup_o,
  input logic [CNT_W-1:0] rd_setup_o,
  input logic [CNT_W-1:0] cs_wr_setup_o,
  input logic [CNT_W-1:0] wr_setup_o,
  input logic [CNT_W-1:0] cs_rd_pulse_o,
  input logic [CNT_W-1:0] rd_pulse_o,
  input logic [CNT_W-1:0] cs_wr_pulse_o,
  input logic [CNT_W-1:0] wr_pulse_o,
  input logic [CYC_W-1:0] rd_cycle_o,
  input logic [CYC_W-1:0] wr_cycle_o
);
  localparam int W = CYC_W + CNT_W + 2;

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);  // R9

  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(rd_cycle_o) && $stable(wr_cycle_o) &&
                 $stable(cs_rd_setup_o) && $stable(wr_pulse_o)));  // R9

  AST_RD_ROOM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && rd_cycle_o != '1) |->
      (W'(rd_cycle_o) >= W'(cs_rd_setup_o) + W'(cs_rd_pulse_o)) &&
      (W'(rd_cycle_o) >= W'(rd_setup_o) + W'(rd_pulse_o)));  // R6

  AST_WR_ROOM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && wr_cycle_o != '1) |->
      (W'(wr_cycle_o) >= W'(cs_wr_setup_o) + W'(cs_wr_pulse_o)) &&
      (W'(wr_cycle_o) >= W'(wr_setup_o) + W'(wr_pulse_o)));  // R7

  AST_BUSY_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i != ST_IDLE && start_i) |=> $stable(scale_i));  // R10

  AST_ZERO_SCALE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && scale_i == '0) |->
      (cs_rd_setup_o == '0 && rd_pulse_o == '0 && cs_wr_pulse_o == '0 &&
       wr_setup_o == '0 && rd_cycle_o <= CYC_W'(1) && wr_cycle_o <= CYC_W'(1)));  // R1
endmodule

bind mem_timing_calc mtc_checker #(.IN_W(IN_W), .CNT_W(CNT_W), .CYC_W(CYC_W)) u_chk (
  .clk_i, .rst_ni, .start_i, .st_i(st_q), .scale_i(scale_q), .done_o,
  .cs_rd_setup_o, .rd_setup_o, .cs_wr_setup_o, .wr_setup_o,
  .cs_rd_pulse_o, .rd_pulse_o, .cs_wr_pulse_o, .wr_pulse_o,
  .rd_cycle_o, .wr_cycle_o
);

// File: tb/tb_mem_timing_calc.sv
module tb_mem_timing_calc;
  localparam int IN_W = 32, CNT_W = 6, CYC_W = 9, NP = 14;

  logic clk = 1'b0, rst_ni = 1'b0, start = 1'b0;
  logic [31:0] hz = '0;
  logic [31:0] tv [NP];
  logic done;
  logic [CNT_W-1:0] so [8];
  logic [CYC_W-1:0] rdc, wrc;
  int checks = 0, errors = 0;
  longint unsigned exp_f [10];

  always #5 clk = ~clk;

  mem_timing_calc #(.IN_W(IN_W), .CNT_W(CNT_W), .CYC_W(CYC_W)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start), .clk_hz_i(hz),
    .cs_rd_setup_ns_i(tv[0]), .rd_setup_ns_i(tv[1]), .cs_wr_setup_ns_i(tv[2]),
    .wr_setup_ns_i(tv[3]), .cs_rd_pulse_ns_i(tv[4]), .rd_pulse_ns_i(tv[5]),
    .cs_wr_pulse_ns_i(tv[6]), .wr_pulse_ns_i(tv[7]), .rd_total_ns_i(tv[8]),
    .wr_total_ns_i(tv[9]), .cs_rd_rec_ns_i(tv[10]), .rd_rec_ns_i(tv[11]),
    .cs_wr_rec_ns_i(tv[12]), .wr_rec_ns_i(tv[13]), .done_o(done),
    .cs_rd_setup_o(so[0]), .rd_setup_o(so[1]), .cs_wr_setup_o(so[2]),
    .wr_setup_o(so[3]), .cs_rd_pulse_o(so[4]), .rd_pulse_o(so[5]),
    .cs_wr_pulse_o(so[6]), .wr_pulse_o(so[7]),
    .rd_cycle_o(rdc), .wr_cycle_o(wrc)
  );

  task automatic check(input string req, input longint unsigned act,
                       input longint unsigned expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, expv);
    end
  endtask

  function automatic longint unsigned to_cyc(input longint unsigned ns,
                                             input longint unsigned sc,
                                             input bit rec);
    if (ns == 0) return rec ? 1 : 0;
    return (ns * sc + 65535) >> 16;
  endfunction

  function automatic longint unsigned satv(input longint unsigned v, input int w);
    longint unsigned lim = (64'd1 << w) - 1;
    return (v > lim) ? lim : v;
  endfunction

  function automatic longint unsigned mx3(input longint unsigned a,
                                          input longint unsigned b,
                                          input longint unsigned c);
    longint unsigned m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  // expected values for the current hz/tv
  task automatic compute_exp();
    longint unsigned sc, c [NP];
    sc = ((longint'(hz) / 10000) << 16) / 100000;
    for (int i = 0; i < NP; i++) c[i] = to_cyc(longint'(tv[i]), sc, i >= 10);
    for (int i = 0; i < 8; i++) exp_f[i] = satv(c[i], CNT_W);
    exp_f[8] = satv(mx3(c[8], c[0] + c[4] + c[10], c[1] + c[5] + c[11]), CYC_W);
    exp_f[9] = satv(mx3(c[9], c[2] + c[6] + c[12], c[3] + c[7] + c[13]), CYC_W);
  endtask

  task automatic compare_all(input string req);
    for (int i = 0; i < 8; i++) check(req, longint'(so[i]), exp_f[i]);
    check(req, longint'(rdc), exp_f[8]);
    check(req, longint'(wrc), exp_f[9]);
  endtask

  // pulse start, wait for done; returns latency in cycles
  task automatic launch(output int lat);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    lat = 0;
    while (!done && lat < 100) begin
      @(negedge clk); lat++;
    end
  endtask

  task automatic run(input string req);
    int lat;
    compute_exp();
    launch(lat);
    check("R8 latency", longint'(lat), 15);
    compare_all(req);
  endtask

  initial begin
    int lat;
    for (int i = 0; i < NP; i++) tv[i] = '0;
    repeat (3) @(negedge clk);
    // reset state (R9)
    check("R9 reset done", longint'(done), 0);
    for (int i = 0; i < 8; i++) check("R9 reset field", longint'(so[i]), 0);
    check("R9 reset rd", longint'(rdc), 0);
    rst_ni = 1'b1;

    // all zero: recover counts as 1 (R4, R3)
    hz = 32'd100_000_000;
    run("R4/R3 all zero");
    check("R4 rd_cycle", longint'(rdc), 1);
    check("R4 wr_cycle", longint'(wrc), 1);

    // rounding at 100 MHz (R2)
    tv[0] = 10; tv[1] = 11; tv[4] = 1;
    run("R2 rounding");
    check("R2 10ns", longint'(so[0]), 1);
    check("R2 11ns", longint'(so[1]), 2);

    // clock below 10 kHz gives zero factor (R1)
    hz = 32'd9999; tv[0] = 1000; tv[5] = 5000; tv[11] = 200;
    run("R1 slow clock");
    check("R1 zero scale", longint'(so[0]), 0);

    // saturation (R5)
    hz = 32'd133_000_000;
    for (int i = 0; i < NP; i++) tv[i] = 32'd3000;
    run("R5 saturation");
    check("R5 field max", longint'(so[3]), 63);
    check("R5 cycle max", longint'(rdc), 511);

    // stretch from strobe terms over small total (R6, R7)
    hz = 32'd100_000_000;
    for (int i = 0; i < NP; i++) tv[i] = '0;
    tv[1] = 30; tv[5] = 40; tv[11] = 20; tv[8] = 10;
    tv[2] = 50; tv[6] = 60; tv[9] = 20;
    run("R6/R7 stretch");
    check("R6 read from strobe", longint'(rdc), 9);
    check("R7 write from cs", longint'(wrc), 12);

    // mid-conversion start and input change ignored (R8, R10)
    tv[0] = 70; tv[4] = 90;
    compute_exp();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    @(negedge clk);
    hz = 32'hFFFF_FFFF;
    for (int i = 0; i < NP; i++) tv[i] = 32'd777;
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    lat = 2;
    while (!done && lat < 100) begin
      @(negedge clk); lat++;
    end
    check("R10 latency unchanged", longint'(lat), 15);
    compare_all("R8/R10 captured inputs");
    // done one cycle, outputs hold (R9)
    @(negedge clk);
    check("R9 done pulse", longint'(done), 0);
    repeat (5) @(negedge clk);
    compare_all("R9 hold");

    // sweep
    for (int f = 0; f < 7; f++) begin
      case (f)
        0: hz = 32'd9999;
        1: hz = 32'd50_000;
        2: hz = 32'd1_000_000;
        3: hz = 32'd33_000_000;
        4: hz = 32'd66_666_666;
        5: hz = 32'd133_000_000;
        default: hz = 32'hFFFF_FFFF;
      endcase
      for (int k = 0; k < 60; k++) begin
        for (int i = 0; i < NP; i++)
          tv[i] = ((k + i) % 5 == 0) ? 32'd0
                : 32'(((k * 7 + i * 13) % 97) << (k % 6));
        run("R2/R3/R5/R6/R7 sweep");
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1_500_000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule